// File: doc/BRIEF.md
# Prescaled 9-bit PWM Channel

This block is one pulse-width-modulated output channel. Its period is built from one of three reference tick strobes, a small pre-divider chosen from {1, 3, 5, 6} and a power-of-two exponent M from 0 to 7. The period is always split into 512 equal steps, and the output is high for the first `duty` of them. Software programs the channel through a simple write port: a 3-bit address and 9 bits of data, written in one cycle.

The duty can come from the channel's own duty register. It can also come from a live `ramp_duty` input driven by an external ramp generator. A sync write restarts the period counters, so that several channels written in the same cycle start in step. A glitch-removal control selects how new period and duty settings take effect:

- When it is set, new settings are staged and applied only after the end of the current period.
- When it is clear, new settings take effect almost at once.

A one-cycle `period_strobe` marks the last cycle of every period.

Top module: `prescaled_pwm9`

## Requirements
- R1: After reset every setting is zero, and `pwm_out` and `period_strobe` are low.
- R2: The write port has the following register map:
  - Address 0: clock select in bits 1:0. 0 means no clock, 1 selects `ref_tick[0]`, 2 selects `ref_tick[1]`, 3 selects `ref_tick[2]`.
  - Address 1: divisor select in bits 6:5, where 0, 1, 2 and 3 give 1, 3, 5 and 6. Exponent M in bits 2:0.
  - Address 2: duty in bits 8:0.
  - Address 3: output enable in bit 7 and ramp source in bit 1.
  - Address 4: sync in bit 0.
  - Address 5: glitch removal in bit 5.

  One period lasts 512 × divisor × 2^M selected ticks. `period_strobe` is high in its last cycle.
- R3: In each period, `pwm_out` is high for the first duty × divisor × 2^M ticks and low for the rest.
- R4: While the applied clock select is 0, no period strobe occurs and `pwm_out` stays low, even with output enable set.
- R5: With output enable clear, `pwm_out` is constantly low while the period counters keep running and strobing.
- R6: A duty of 0 gives a constant low output. A duty of 511 gives high for 511 of the 512 steps.
- R7: With the ramp source bit set, the applied duty is taken from `ramp_duty`, whatever the duty register holds. With the bit clear, the duty register is used.
- R8: A write of 1 to sync bit 0 restarts the channel at step 0 in the next cycle and applies the staged settings. With a tick in every cycle, the first strobe falls in the (512 × divisor × 2^M)-th cycle after the write edge.
- R9: With glitch removal set, changed clock, divisor, exponent or duty settings are held back. They apply from the cycle after the next period strobe, so the current period finishes with the old values.
- R10: With glitch removal clear, changed settings apply one cycle after the register write is captured.
- R11: While the applied clock select is 0, staged settings are applied every cycle, even with glitch removal set, so a stopped channel can be started without a sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 3 | Reference tick-enable strobes for clock selects 1, 2 and 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 9 | Register write data |
| ramp_duty | input | 9 | Duty from an external ramp generator |
| pwm_out | output | 1 | PWM level |
| period_strobe | output | 1 | High in the last cycle of each period |

## Verification
The hard collision is a duty write that arrives in the middle of a period. Whether it lands in the current period or only after the next strobe depends on the glitch-removal bit.

The bench issues a sync and then drives a duty write in the tenth cycle of the window. It counts the high cycles of that period and of the following one. With glitch removal set, the current period must still show the old duty and the next period the new one. With glitch removal clear, the new duty must stretch the current period at once.

A second overlap is a sync that lands in a strobe cycle, where the restart wins. This is guarded by the in-design properties.

// File: rtl/pwm9_pkg.sv
package pwm9_pkg;
    localparam int CLKSEL_BITS = 2;
    localparam int DIVSEL_BITS = 2;
    localparam int EXP_BITS    = 3;
    localparam int RES_BITS    = 9;
    localparam int NUM_REFS    = (1 << CLKSEL_BITS) - 1;

    typedef enum logic [2:0] {
        ADDR_CLK   = 3'd0,
        ADDR_DIV   = 3'd1,
        ADDR_DUTY  = 3'd2,
        ADDR_CTRL  = 3'd3,
        ADDR_SYNC  = 3'd4,
        ADDR_TYPE  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [CLKSEL_BITS-1:0] clk_sel;
        logic [DIVSEL_BITS-1:0] div_sel;
        logic [EXP_BITS-1:0]    expo;
        logic [RES_BITS-1:0]    duty;
    } pwm_cfg_t;

    typedef struct packed {
        logic [CLKSEL_BITS-1:0] clk_sel;
        logic [DIVSEL_BITS-1:0] div_sel;
        logic [EXP_BITS-1:0]    expo;
        logic [RES_BITS-1:0]    duty;
        logic                   out_en;
        logic                   src_ramp;
        logic                   glitch_en;
        pwm_cfg_t               act;
    } chan_regs_t;
endpackage

// File: rtl/pwm_ref_sel.sv
module pwm_ref_sel
    import pwm9_pkg::*;
#(
    parameter int SEL_W = CLKSEL_BITS,
    localparam int NREF = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [NREF-1:0]  ref_tick,
    output logic             tick
);
    logic [NREF-1:0] hit;

    for (genvar i = 0; i < NREF; i++) begin : g_ref
        assign hit[i] = ref_tick[i] && (sel == SEL_W'(i + 1));
    end

    assign tick = |hit;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm9_pkg::*;
#(
    parameter int DSEL_W = DIVSEL_BITS,
    parameter int EXP_W  = EXP_BITS,
    localparam int CNT_W = 3 + (1 << EXP_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sync,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic [EXP_W-1:0]  expo,
    output logic              step_tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t q, d;
    logic [CNT_W-1:0] limit;
    logic             last;

    function automatic logic [CNT_W-1:0] step_len(input logic [DSEL_W-1:0] s,
                                                  input logic [EXP_W-1:0] e);
        logic [CNT_W-1:0] base;
        if (int'(s) == 0)      base = CNT_W'(1);
        else if (int'(s) == 1) base = CNT_W'(3);
        else if (int'(s) == 2) base = CNT_W'(5);
        else                   base = CNT_W'(6);
        return base << e;
    endfunction

    always_comb begin
        d     = q;
        limit = step_len(div_sel, expo);
        last  = (q.cnt >= (limit - CNT_W'(1)));
        step_tick = tick && last;
        if (sync) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = last ? '0 : q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: with no selected tick the prescaler does not move
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sync) |=> $stable(q.cnt));
endmodule

// File: rtl/pwm_step_gen.sv
module pwm_step_gen
    import pwm9_pkg::*;
#(
    parameter int RES_W = RES_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_tick,
    input  logic             sync,
    input  logic [RES_W-1:0] duty,
    input  logic             out_en,
    input  logic             clk_on,
    output logic             pwm_out,
    output logic             boundary
);
    localparam logic [RES_W-1:0] STEP_LAST = '1;

    typedef struct packed {
        logic [RES_W-1:0] step;
    } step_state_t;

    step_state_t q, d;

    always_comb begin
        d        = q;
        boundary = step_tick && (q.step == STEP_LAST) && !sync;
        if (sync)           d.step = '0;
        else if (step_tick) d.step = q.step + RES_W'(1);
        pwm_out = out_en && clk_on && (q.step < duty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a sync restarts at step zero
    a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (q.step == '0));
    // R2: a period ends by wrapping to step zero
    a_r2_wrap_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (q.step == '0));
endmodule

// File: rtl/prescaled_pwm9.sv
module prescaled_pwm9
    import pwm9_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_tick,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [RES_BITS-1:0] wr_data,
    input  logic [RES_BITS-1:0] ramp_duty,
    output logic                pwm_out,
    output logic                period_strobe
);
    chan_regs_t q, d;
    pwm_cfg_t   staged;
    logic       sync;
    logic       sel_tick;
    logic       step_tick;
    logic       boundary;

    always_comb begin
        d    = q;
        sync = wr_en && (wr_addr == ADDR_SYNC) && wr_data[0];
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CLK:  d.clk_sel = wr_data[CLKSEL_BITS-1:0];
                ADDR_DIV: begin
                    d.div_sel = wr_data[6:5];
                    d.expo    = wr_data[EXP_BITS-1:0];
                end
                ADDR_DUTY: d.duty = wr_data;
                ADDR_CTRL: begin
                    d.out_en   = wr_data[7];
                    d.src_ramp = wr_data[1];
                end
                ADDR_TYPE: d.glitch_en = wr_data[5];
                default: ;
            endcase
        end
        staged.clk_sel = q.clk_sel;
        staged.div_sel = q.div_sel;
        staged.expo    = q.expo;
        staged.duty    = q.src_ramp ? ramp_duty : q.duty;
        if (!q.glitch_en || boundary || sync || (q.act.clk_sel == '0))
            d.act = staged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    pwm_ref_sel #(.SEL_W(CLKSEL_BITS)) u_ref_sel (
        .sel      (q.act.clk_sel),
        .ref_tick (ref_tick),
        .tick     (sel_tick)
    );

    pwm_prescaler #(.DSEL_W(DIVSEL_BITS), .EXP_W(EXP_BITS)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sel_tick),
        .sync      (sync),
        .div_sel   (q.act.div_sel),
        .expo      (q.act.expo),
        .step_tick (step_tick)
    );

    pwm_step_gen #(.RES_W(RES_BITS)) u_step_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .sync      (sync),
        .duty      (q.act.duty),
        .out_en    (q.out_en),
        .clk_on    (q.act.clk_sel != '0),
        .pwm_out   (pwm_out),
        .boundary  (boundary)
    );

    assign period_strobe = boundary;

    // R6: zero duty never drives high
    a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act.duty == '0) |-> !pwm_out);
    // R4: no strobe without a running reference
    a_r4_strobe_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> (q.act.clk_sel != '0));
    // R9: staged settings wait for the period end
    a_r9_glitch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.glitch_en && !boundary && !sync && (q.act.clk_sel != '0)) |=> $stable(q.act));
    // R11: a stopped channel takes staged settings at once
    a_r11_stopped_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act.clk_sel == '0) |=> (q.act == $past(staged)));
endmodule

// File: tb/prescaled_pwm9_tb.sv
`timescale 1ns/1ps
module prescaled_pwm9_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ref_tick = 3'b000;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [8:0] wr_data = 9'd0;
    logic [8:0] ramp_duty = 9'd0;
    logic       pwm_out;
    logic       period_strobe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [31:0] cyc = 0;

    prescaled_pwm9 u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_tick      (ref_tick),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .ramp_duty     (ramp_duty),
        .pwm_out       (pwm_out),
        .period_strobe (period_strobe)
    );

    always #2 clk = ~clk;

    // Tick rates: ref_tick[0] every 4th cycle, [1] every 2nd, [2] every cycle.
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            ref_tick = {1'b1, ~cyc[0], (cyc[1:0] == 2'b00)};
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int div_of(input int s);
        case (s)
            0: return 1;
            1: return 3;
            2: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic wait_strobe(input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (period_strobe) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure(input int maxc, output int len, output int hi);
        len = 0; hi = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            len++;
            if (pwm_out) hi++;
            if (period_strobe) break;
        end
    endtask

    task automatic count_window(input int cycles, output int hi, output int strobes);
        hi = 0; strobes = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (period_strobe) strobes++;
        end
    endtask

    // Sync, then optionally write a new duty in cycle wr_at; count highs per half.
    task automatic sync_window(input int total, input int wr_at, input logic [8:0] v,
                               output int hi1, output int hi2, output int strobe_at);
        hi1 = 0; hi2 = 0; strobe_at = 0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 9'd1;
        for (int n = 1; n <= total; n++) begin
            @(negedge clk);
            if (pwm_out) begin
                if (n <= 512) hi1++; else hi2++;
            end
            if (period_strobe && strobe_at == 0) strobe_at = n;
            wr_en = 1'b0;
            if (n == wr_at) begin
                wr_en = 1'b1; wr_addr = 3'd2; wr_data = v;
            end
        end
        wr_en = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int len, hi, hi2, st, strobes;
        bit ok;
        void'($urandom(32'h00C0FFEE));

        repeat (3) @(negedge clk);
        chk("R1 pwm_out in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm_out after reset", int'(pwm_out), 0);
        chk("R1 strobe after reset", int'(period_strobe), 0);

        // R11: glitch removal on while stopped, start without sync
        wr(3'd5, 9'h020);
        wr(3'd1, 9'h000);
        wr(3'd2, 9'd100);
        wr(3'd3, 9'h080);
        wr(3'd3, 9'h080);
        wr(3'd0, 9'd3);
        wait_strobe(600, ok);
        chk("R11 stopped channel starts", int'(ok), 1);
        measure(600, len, hi);
        chk("R11 period length", len, 512);
        chk("R3 high count duty 100", hi, 100);

        // R9: glitch removal holds a mid-period duty write
        sync_window(1024, 10, 9'd300, hi, hi2, st);
        chk("R8 first strobe after sync", st, 512);
        chk("R9 current period keeps old duty", hi, 100);
        chk("R9 next period takes new duty", hi2, 300);

        // R10: glitch removal off, a mid-period write applies at once
        wr(3'd5, 9'h000);
        wr(3'd2, 9'd100);
        sync_window(512, 10, 9'd300, hi, hi2, st);
        chk("R10 immediate duty update", hi, 300);

        // R6 corners
        wr(3'd2, 9'd0);
        sync_window(512, 0, 9'd0, hi, hi2, st);
        chk("R6 duty 0 stays low", hi, 0);
        wr(3'd2, 9'd511);
        sync_window(512, 0, 9'd0, hi, hi2, st);
        chk("R6 duty 511 high count", hi, 511);

        // R7: ramp source wins over register duty
        ramp_duty = 9'd77;
        wr(3'd2, 9'd300);
        wr(3'd3, 9'h086);
        sync_window(512, 0, 9'd0, hi, hi2, st);
        chk("R7 ramp duty used", hi, 77);
        wr(3'd3, 9'h084);
        sync_window(512, 0, 9'd0, hi, hi2, st);
        chk("R7 register duty used", hi, 300);

        // R5: disabled output is low, strobes continue
        wr(3'd3, 9'h004);
        sync_window(512, 0, 9'd0, hi, hi2, st);
        count_window(1024, hi, strobes);
        chk("R5 disabled output low", hi, 0);
        chk("R5 strobes continue", strobes, 2);

        // R4: clock select 0 stops everything even if enabled
        wr(3'd3, 9'h084);
        wr(3'd0, 9'd0);
        count_window(2000, hi, strobes);
        chk("R4 no output without clock", hi, 0);
        chk("R4 no strobe without clock", strobes, 0);

        // R2 directed: divisor 5, M=2, every-cycle ticks
        wr(3'd0, 9'd3);
        wr(3'd1, 9'h042);
        wr(3'd2, 9'd33);
        sync_window(0, 0, 9'd0, hi, hi2, st);
        wait_strobe(11000, ok);
        measure(11000, len, hi);
        chk("R2 period div5 M2", len, 512 * 5 * 4);
        chk("R3 high div5 M2", hi, 33 * 5 * 4);

        // Random trials on R2/R3
        for (int t = 0; t < 6; t++) begin
            int sel, ds, m, du, rate, l, exp_len;
            sel  = 2 + int'($urandom % 2);
            ds   = int'($urandom % 4);
            m    = (sel == 3) ? int'($urandom % 2) : 0;
            du   = int'($urandom % 512);
            rate = (sel == 3) ? 1 : 2;
            l    = div_of(ds) << m;
            exp_len = 512 * l * rate;
            wr(3'd1, 9'((ds << 5) | m));
            wr(3'd2, 9'(du));
            wr(3'd0, 9'(sel));
            sync_window(0, 0, 9'd0, hi, hi2, st);
            wait_strobe(exp_len + 16, ok);
            measure(exp_len + 16, len, hi);
            chk("R2 random period length", len, exp_len);
            chk("R3 random high count", hi, du * l * rate);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule